// File: doc/BRIEF.md
# Glitch-Free Output Bank Gating

This block sits between a shared internal clock and five clock outputs: four differential output banks and one differential feedback output. An 8-bit configuration byte, written through a simple strobe interface in its own clock domain, decides which outputs run. Software may change that byte at any moment, with no phase relation to the output clock. The block carries each enable across into the output-clock domain and applies it only while the clock is low. No output ever shows a shortened high phase.

A stopped output parks with its true leg at 0 and its complement leg at 1. The feedback output is forced on whenever external-feedback mode is selected, whatever its enable bit holds. The three upper bits of the byte have simple effects. One masks the interrupt pin. One gates the four clock-valid qualifier lines. One is passed out as a slew-direction select for logic outside this block. Reads return the stored byte, not the effective gating state.

Top module: `out_bank_gate`

## Requirements
- R1: After reset the stored byte reads 0x00, and every bank and the feedback output stay parked (true leg 0, complement leg 1) until software enables them.
- R2: When `wr_en` is high at a rising `cfg_clk` edge, `wr_data` is stored, and `rd_data` returns the stored byte from then on. The layout is: bit 7 interrupt enable, bit 6 qualifier enable, bit 5 slew select, bit 4 feedback enable, bits 3..0 bank enables. Bank A is bit 3, B bit 2, C bit 1, D bit 0. `bank_q[i]` is driven by bit i.
- R3: Bank i runs during the high phase that begins at `out_clk` rising edge n exactly when its enable bit was 1 just before rising edge n-2.
- R4: A bank whose enable is 0, after the same two-edge delay, holds `bank_q[i]`=0 and `bank_qn[i]`=1 for the whole period.
- R5: Outputs change only on `out_clk` edges. Every high pulse on a running output spans the full high phase of `out_clk`, even when the byte is rewritten on consecutive cycles.
- R6: Each complement leg is always the inverse of its true leg.
- R7: The feedback output follows bit 4 with the same delay as R3. While `ext_fb` is 1, it runs regardless of bit 4.
- R8: `int_pin` equals `int_flag` when bit 7 is 1 and is 0 when bit 7 is 0.
- R9: `clk_valid_out` equals `clk_valid_in` when bit 6 is 1 and is all zero when bit 6 is 0.
- R10: `slew_dir` reflects stored bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register interface clock |
| cfg_rst | input | 1 | Synchronous active-high reset, register domain |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Stored byte |
| int_flag | input | 1 | Internal interrupt flag |
| int_pin | output | 1 | Masked interrupt output |
| clk_valid_in | input | 4 | Clock-valid qualifier lines |
| clk_valid_out | output | 4 | Qualifier lines after gating |
| slew_dir | output | 1 | Slew direction select |
| out_clk | input | 1 | Shared internal output clock |
| out_rst | input | 1 | Synchronous active-high reset, output domain |
| ext_fb | input | 1 | External-feedback mode select |
| bank_q | output | 4 | True legs of banks (bit 3 = A) |
| bank_qn | output | 4 | Complement legs of banks |
| fb_q | output | 1 | True leg of feedback output |
| fb_qn | output | 1 | Complement leg of feedback output |

## Verification
The stored byte, the interrupt mask, the qualifier gate and the slew select take effect on the first `cfg_clk` edge after the write. The bench checks them in the middle of every output-clock high phase against its own copy of the byte. A bank or feedback enable reaches the output on the third `out_clk` rising edge after the byte is first seen. The bench's reference model holds the last two sampled enable words in a queue, takes the older word at each falling edge, and compares it to the outputs in mid-high. In mid-low, every output must be parked. The register clock runs 3 ns out of phase with the output clock, and any output transition off a multiple of 4 ns is flagged as a runt.

// File: rtl/out_gate_pkg.sv
package out_gate_pkg;

    localparam int unsigned NUM_BANKS = 4;
    localparam int unsigned NUM_OUT   = NUM_BANKS + 1;
    localparam int unsigned CFG_W     = 8;
    localparam int unsigned QUAL_W    = 4;

    // Packed in register bit order: first field is bit 7.
    typedef struct packed {
        logic                 int_en;
        logic                 qual_en;
        logic                 slew_lag;
        logic                 fb_en;
        logic [NUM_BANKS-1:0] bank_en;
    } gate_cfg_t;

    // Request word handed to the output domain: feedback on top, banks below.
    function automatic logic [NUM_OUT-1:0] run_request(gate_cfg_t c, logic ext_fb_mode);
        return {c.fb_en | ext_fb_mode, c.bank_en};
    endfunction

endpackage

// File: rtl/gate_cfg_reg.sv
module gate_cfg_reg
    import out_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output gate_cfg_t        cfg
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (wr_en)
            cfg <= gate_cfg_t'(wr_data);
    end

    // R2
    write_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (CFG_W'(cfg) == $past(wr_data)));

    // R2
    hold_store_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));

endmodule

// File: rtl/gate_sync.sv
module gate_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++)
                chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gate_cell.sv
module gate_cell (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic q,
    output logic qn
);

    logic hold_run;

    // Captured on the falling edge: the decision can change only while
    // the clock is low, so no high phase is ever cut short.
    always_ff @(negedge clk) begin
        if (rst)
            hold_run <= 1'b0;
        else
            hold_run <= run;
    end

    assign q  = clk & hold_run;
    assign qn = ~q;

endmodule

// File: rtl/out_bank_gate.sv
module out_bank_gate
    import out_gate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              cfg_clk,
    input  logic              cfg_rst,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [CFG_W-1:0]  rd_data,
    input  logic              int_flag,
    output logic              int_pin,
    input  logic [QUAL_W-1:0] clk_valid_in,
    output logic [QUAL_W-1:0] clk_valid_out,
    output logic              slew_dir,
    input  logic              out_clk,
    input  logic              out_rst,
    input  logic              ext_fb,
    output logic [NUM_BANKS-1:0] bank_q,
    output logic [NUM_BANKS-1:0] bank_qn,
    output logic              fb_q,
    output logic              fb_qn
);

    localparam int unsigned FB_IDX = NUM_OUT - 1;

    gate_cfg_t            cfg;
    logic [NUM_OUT-1:0]   req_async;
    logic [NUM_OUT-1:0]   req_sync;
    logic [NUM_OUT-1:0]   gq;
    logic [NUM_OUT-1:0]   gqn;

    gate_cfg_reg u_cfg (
        .clk     (cfg_clk),
        .rst     (cfg_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    assign rd_data       = CFG_W'(cfg);
    assign int_pin       = int_flag & cfg.int_en;
    assign clk_valid_out = cfg.qual_en ? clk_valid_in : '0;
    assign slew_dir      = cfg.slew_lag;

    assign req_async = run_request(cfg, ext_fb);

    gate_sync #(
        .WIDTH  (NUM_OUT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (out_clk),
        .rst (out_rst),
        .d   (req_async),
        .q   (req_sync)
    );

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
            gate_cell u_cell (
                .clk (out_clk),
                .rst (out_rst),
                .run (req_sync[i]),
                .q   (gq[i]),
                .qn  (gqn[i])
            );
        end
    endgenerate

    assign bank_q  = gq[NUM_BANKS-1:0];
    assign bank_qn = gqn[NUM_BANKS-1:0];
    assign fb_q    = gq[FB_IDX];
    assign fb_qn   = gqn[FB_IDX];

    // R8
    int_mask_chk: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
        int_pin |-> (int_flag && rd_data[7]));

    // R9
    qual_off_chk: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
        !rd_data[6] |-> (clk_valid_out == '0));

    generate
        if (SYNC_STAGES == 2) begin : g_sync_chk
            // R3
            sync_delay_chk: assert property (@(posedge out_clk) disable iff (out_rst)
                (!$past(out_rst) && !$past(out_rst, 2)) |-> (req_sync == $past(req_async, 2)));

            // R7
            ext_fb_force_chk: assert property (@(posedge out_clk) disable iff (out_rst)
                (!$past(out_rst) && !$past(out_rst, 2) && $past(ext_fb, 2)) |-> req_sync[FB_IDX]);
        end
    endgenerate

endmodule

// File: tb/sim_out_bank_gate.sv
`timescale 1ns/1ps
module sim_out_bank_gate;

    logic       cfg_clk, cfg_rst, wr_en;
    logic [7:0] wr_data, rd_data;
    logic       int_flag, int_pin;
    logic [3:0] clk_valid_in, clk_valid_out;
    logic       slew_dir;
    logic       out_clk, out_rst, ext_fb;
    logic [3:0] bank_q, bank_qn;
    logic       fb_q, fb_qn;

    int checks = 0;
    int errors = 0;
    bit chk_on = 0;
    bit done   = 0;

    logic [7:0] reg_m;
    logic [4:0] pipe_q[$];
    logic [4:0] exp_g;

    out_bank_gate u0 (
        .cfg_clk(cfg_clk), .cfg_rst(cfg_rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .int_flag(int_flag), .int_pin(int_pin),
        .clk_valid_in(clk_valid_in), .clk_valid_out(clk_valid_out),
        .slew_dir(slew_dir), .out_clk(out_clk), .out_rst(out_rst), .ext_fb(ext_fb),
        .bank_q(bank_q), .bank_qn(bank_qn), .fb_q(fb_q), .fb_qn(fb_qn)
    );

    // 125 MHz output clock; register clock at the same rate, 3 ns out of phase.
    initial begin out_clk = 0; forever #4 out_clk = ~out_clk; end
    initial begin cfg_clk = 0; #3; forever #4 cfg_clk = ~cfg_clk; end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: stored byte, two-word request queue, falling-edge pick.
    always @(posedge cfg_clk) begin
        if (cfg_rst) reg_m <= 8'h00;
        else if (wr_en) reg_m <= wr_data;
    end

    always @(posedge out_clk) begin
        if (out_rst) pipe_q.delete();
        else begin
            pipe_q.push_back({reg_m[4] | ext_fb, reg_m[3:0]});
            if (pipe_q.size() > 2) void'(pipe_q.pop_front());
        end
    end

    always @(negedge out_clk) begin
        if (out_rst) exp_g <= 5'b0;
        else exp_g <= (pipe_q.size() == 2) ? pipe_q[0] : 5'b0;
    end

    // Compare every cycle: mid-high and mid-low.
    always @(posedge out_clk) begin
        #2;
        if (chk_on) begin
            chk("R3 bank run", {28'b0, bank_q}, {28'b0, exp_g[3:0]});
            chk("R4 bank park n-leg", {28'b0, bank_qn}, {28'b0, ~exp_g[3:0]});
            chk("R6 complement", {28'b0, bank_qn}, {28'b0, ~bank_q});
            chk("R7 feedback run", {31'b0, fb_q}, {31'b0, exp_g[4]});
            chk("R6 fb complement", {31'b0, fb_qn}, {31'b0, ~exp_g[4]});
            chk("R2 readback", {24'b0, rd_data}, {24'b0, reg_m});
            chk("R8 int mask", {31'b0, int_pin}, {31'b0, int_flag & reg_m[7]});
            chk("R9 qualifier", {28'b0, clk_valid_out}, {28'b0, reg_m[6] ? clk_valid_in : 4'b0});
            chk("R10 slew", {31'b0, slew_dir}, {31'b0, reg_m[5]});
        end
        #4;
        if (chk_on) begin
            chk("R5 low phase q", {27'b0, fb_q, bank_q}, 32'h0);
            chk("R5 low phase qn", {27'b0, fb_qn, bank_qn}, 32'h1F);
        end
    end

    // R5: any output transition away from an out_clk edge is a runt.
    always @(bank_q or fb_q) begin
        if (chk_on && ($time % 4) != 0) begin
            checks++;
            errors++;
            $display("FAIL R5 output moved off clock edge actual=%0t expected=multiple of 4ns", $time);
        end
    end

    task automatic wr(logic [7:0] v, int hold);
        @(negedge cfg_clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge cfg_clk);
        wr_en = 1'b0;
        repeat (hold) @(negedge cfg_clk);
    endtask

    initial begin
        cfg_rst = 1; out_rst = 1; wr_en = 0; wr_data = 0;
        ext_fb = 0; int_flag = 0; clk_valid_in = 0;
        repeat (4) @(negedge cfg_clk);
        cfg_rst = 0; out_rst = 0; chk_on = 1;
        repeat (3) @(negedge cfg_clk);
        @(posedge out_clk); #2;
        chk("R1 reset readback", {24'b0, rd_data}, 32'h0);
        chk("R1 reset parked q", {27'b0, fb_q, bank_q}, 32'h0);
        chk("R1 reset parked qn", {27'b0, fb_qn, bank_qn}, 32'h1F);

        wr(8'h0F, 6);
        wr(8'h05, 6);
        clk_valid_in = 4'hA; int_flag = 1;
        wr(8'h1A, 6);
        ext_fb = 1;
        wr(8'h00, 6);
        ext_fb = 0;
        repeat (5) @(negedge cfg_clk);
        wr(8'hC0, 4);
        int_flag = 0; clk_valid_in = 4'h5;
        repeat (3) @(negedge cfg_clk);
        int_flag = 1; clk_valid_in = 4'hF;
        wr(8'h40, 4);
        wr(8'h80, 4);
        wr(8'h20, 4);
        for (int i = 0; i < 16; i++) wr((i % 2 == 0) ? 8'h1F : 8'h00, 0);
        for (int i = 0; i < 8; i++) wr(8'h01 << (i % 4), 1);
        ext_fb = 1;
        for (int i = 0; i < 6; i++) wr((i % 2 == 0) ? 8'h08 : 8'h13, 0);
        ext_fb = 0;
        wr(8'hFF, 8);
        wr(8'h00, 8);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule